// File: doc/BRIEF.md
# 2D Drawing Object Binding Validity Tracker

This block keeps the state of one 2D drawing object. The object has a main state word and an auxiliary word. Method writes reach it through a single strobe that carries three things: a method selector, a data value and the class code of a helper object. These writes select a drawing operation or attach helper objects to the object. The helper objects are surfaces, a pattern, a raster operation, two blend factors, a clip rectangle and a colour key.

After every accepted change to the operation or to a helper-object binding, the block works out a patch-valid bit again. This bit says whether every helper object that the current operation and object class need is attached. A write that the block rejects raises a one-cycle error pulse and leaves all state as it was.

The object class is loaded at reset from the `init_class` input and stays fixed until the next reset. The block has two states:
- `ST_IDLE`: nothing is pending.
- `ST_REVAL`: an accepted write that can affect validity was taken on the previous edge.

Transitions:
- *start* (`ST_IDLE` to `ST_REVAL`) on such a write.
- *chain* (`ST_REVAL` to `ST_REVAL`) when another such write arrives during the recompute.
- *settle* (`ST_REVAL` to `ST_IDLE`) otherwise.
- *hold* (`ST_IDLE` to `ST_IDLE`) when no such write arrives.

Top module: `blit_bind_tracker`

## Requirements
- R1: While reset is asserted, and after it is released, `obj_word0` equals `init_class` in bits 7:0 with every other bit zero. `obj_aux`, `err_pulse` and `patch_valid` are zero.
- R2: An operation write (selector 0) takes its value from `wr_data`. A value above 5 is rejected. A value above 2 is also rejected when the class (`obj_word0[7:0]`) is below 0x40. An accepted value is stored in `obj_word0[17:15]` on the next edge.
- R3: Flag binds set or clear one `obj_aux` bit. Class 0x30 clears the bit. The listed class sets it. The selectors are:
  - selector 1, pattern (old): class 0x18, bit 27
  - selector 2, pattern: class 0x44, bit 27
  - selector 3, raster operation: class 0x43, bit 28
  - selector 4, blend factor 1: class 0x12, bit 29
  - selector 5, blend factor 4: class 0x72, bit 30
  - selector 8, destination surface: class 0x58, bit 25
  - selector 9, source surface: class 0x59, bit 26
  - selector 10, colour surface: class 0x5a, bit 25
  - selector 11, depth surface: class 0x5b, bit 26
- R4: A 2D-surface bind (selector 6) or a swizzle-capable 2D-surface bind (selector 7) acts as follows:
  - class 0x42 sets `obj_aux[25]` and clears `obj_word0[14]`.
  - class 0x30 clears both bits.
  - class 0x52, on selector 7 only, sets both bits.
- R5: A clip bind (selector 12, class 0x19) sets `obj_word0[13]`. A colour-key bind (selector 13, class 0x57) sets `obj_word0[12]`. Class 0x30 on either selector clears its bit.
- R6: The following are rejected:
  - a bind whose class is neither 0x30 nor one accepted by its selector;
  - selectors 14 and 15.

  A rejected write drives `err_pulse` high for exactly the cycle after it and changes neither word.
- R7: The valid bit is 1 only when all of these hold:
  - `obj_aux[25]` is set;
  - for classes 0x1f and 0x48, `obj_aux[26]` is set;
  - operation 1 has bit 27 or bit 28 set; operation 2 has bit 29 set; operations 4 and 5 have bit 30 set; operations 0 and 3 need nothing further.
- R8: The valid bit (`patch_valid`, mirrored in `obj_word0[24]`) is recomputed on the edge after an accepted operation, flag or surface write. Clip and colour-key binds do not start a recompute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_class | input | 8 | Object class loaded at reset |
| wr_en | input | 1 | Method write strobe |
| wr_sel | input | 4 | Method selector |
| wr_data | input | 32 | Operation value for selector 0 |
| wr_class | input | 8 | Class of the object being bound |
| obj_word0 | output | 32 | Main state word |
| obj_aux | output | 32 | Auxiliary word holding the bound flags |
| err_pulse | output | 1 | One-cycle pulse after a rejected write |
| patch_valid | output | 1 | Drawing allowed with the current bindings |

## Verification
The hardest situation to reach from the ports is the full cross of object class, operation and the six bound flags. The class can only change through reset, and the flags can only change through separate bind writes. The stimulus sweeps that cross completely for five classes: for each combination it resets with a new class, issues six binds, each with the matching class or the null class, and then issues one operation write. Classes below 0x40 also reach the rejected operations 3 to 5, so the check confirms that the valid bit still follows the reset-time operation 0.

// File: rtl/bbt_pkg.sv
package bbt_pkg;
    localparam int SEL_W  = 4;
    localparam int CLS_W  = 8;
    localparam int DATA_W = 32;
    localparam int WORD_W = 32;

    localparam logic [SEL_W-1:0] SEL_OP        = 4'd0;
    localparam logic [SEL_W-1:0] SEL_PATT_OLD  = 4'd1;
    localparam logic [SEL_W-1:0] SEL_PATT      = 4'd2;
    localparam logic [SEL_W-1:0] SEL_ROP       = 4'd3;
    localparam logic [SEL_W-1:0] SEL_BLEND1    = 4'd4;
    localparam logic [SEL_W-1:0] SEL_BLEND4    = 4'd5;
    localparam logic [SEL_W-1:0] SEL_SURF2D    = 4'd6;
    localparam logic [SEL_W-1:0] SEL_SURF2D_SW = 4'd7;
    localparam logic [SEL_W-1:0] SEL_DST       = 4'd8;
    localparam logic [SEL_W-1:0] SEL_SRC       = 4'd9;
    localparam logic [SEL_W-1:0] SEL_COLOR     = 4'd10;
    localparam logic [SEL_W-1:0] SEL_DEPTH     = 4'd11;
    localparam logic [SEL_W-1:0] SEL_CLIP      = 4'd12;
    localparam logic [SEL_W-1:0] SEL_CKEY      = 4'd13;

    localparam logic [CLS_W-1:0] CLS_NULL      = 8'h30;
    localparam logic [CLS_W-1:0] CLS_PATT_OLD  = 8'h18;
    localparam logic [CLS_W-1:0] CLS_PATT      = 8'h44;
    localparam logic [CLS_W-1:0] CLS_ROP       = 8'h43;
    localparam logic [CLS_W-1:0] CLS_BLEND1    = 8'h12;
    localparam logic [CLS_W-1:0] CLS_BLEND4    = 8'h72;
    localparam logic [CLS_W-1:0] CLS_SURF2D    = 8'h42;
    localparam logic [CLS_W-1:0] CLS_SWZ       = 8'h52;
    localparam logic [CLS_W-1:0] CLS_DST       = 8'h58;
    localparam logic [CLS_W-1:0] CLS_SRC       = 8'h59;
    localparam logic [CLS_W-1:0] CLS_COLOR     = 8'h5a;
    localparam logic [CLS_W-1:0] CLS_DEPTH     = 8'h5b;
    localparam logic [CLS_W-1:0] CLS_CLIP      = 8'h19;
    localparam logic [CLS_W-1:0] CLS_CKEY      = 8'h57;
    localparam logic [CLS_W-1:0] CLS_OLD_LIMIT = 8'h40;
    localparam logic [CLS_W-1:0] CLS_TWO_SRC_A = 8'h1f;
    localparam logic [CLS_W-1:0] CLS_TWO_SRC_B = 8'h48;

    localparam int B_CKEY  = 12;
    localparam int B_CLIP  = 13;
    localparam int B_SWZ   = 14;
    localparam int B_OP_LO = 15;
    localparam int B_VALID = 24;
    localparam int B_DST   = 25;
    localparam int B_SRC   = 26;
    localparam int B_PATT  = 27;
    localparam int B_ROP   = 28;
    localparam int B_BL1   = 29;
    localparam int B_BL4   = 30;

    localparam int OP_MAX     = 5;
    localparam int OP_OLD_MAX = 2;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_REVAL = 1'b1
    } bbt_state_e;
endpackage

// File: rtl/bbt_decode.sv
module bbt_decode
    import bbt_pkg::*;
(
    input  logic [SEL_W-1:0]  sel,
    input  logic [CLS_W-1:0]  cls,
    input  logic [DATA_W-1:0] data,
    input  logic [WORD_W-1:0] w0,
    input  logic [WORD_W-1:0] aux,
    output logic              ok,
    output logic              reval,
    output logic [WORD_W-1:0] w0_n,
    output logic [WORD_W-1:0] aux_n
);
    localparam int IDX_W = $clog2(WORD_W);

    logic             is_flag;
    logic             tgt_aux;
    logic [IDX_W-1:0] tgt_bit;
    logic [CLS_W-1:0] want;

    // Selector to (matching class, target bit) for simple flag binds
    always_comb begin
        is_flag = 1'b1;
        tgt_aux = 1'b1;
        tgt_bit = IDX_W'(B_DST);
        want    = CLS_DST;
        case (sel)
            SEL_PATT_OLD: begin want = CLS_PATT_OLD; tgt_bit = IDX_W'(B_PATT); end
            SEL_PATT:     begin want = CLS_PATT;     tgt_bit = IDX_W'(B_PATT); end
            SEL_ROP:      begin want = CLS_ROP;      tgt_bit = IDX_W'(B_ROP);  end
            SEL_BLEND1:   begin want = CLS_BLEND1;   tgt_bit = IDX_W'(B_BL1);  end
            SEL_BLEND4:   begin want = CLS_BLEND4;   tgt_bit = IDX_W'(B_BL4);  end
            SEL_DST:      begin want = CLS_DST;      tgt_bit = IDX_W'(B_DST);  end
            SEL_SRC:      begin want = CLS_SRC;      tgt_bit = IDX_W'(B_SRC);  end
            SEL_COLOR:    begin want = CLS_COLOR;    tgt_bit = IDX_W'(B_DST);  end
            SEL_DEPTH:    begin want = CLS_DEPTH;    tgt_bit = IDX_W'(B_SRC);  end
            SEL_CLIP:     begin want = CLS_CLIP; tgt_bit = IDX_W'(B_CLIP); tgt_aux = 1'b0; end
            SEL_CKEY:     begin want = CLS_CKEY; tgt_bit = IDX_W'(B_CKEY); tgt_aux = 1'b0; end
            default:      is_flag = 1'b0;
        endcase
    end

    // Apply the write to copies of the state words
    always_comb begin
        w0_n  = w0;
        aux_n = aux;
        ok    = 1'b0;
        reval = 1'b0;
        if (is_flag) begin
            if (cls == CLS_NULL || cls == want) begin
                ok    = 1'b1;
                reval = tgt_aux;
                if (tgt_aux) aux_n[tgt_bit] = (cls == want);
                else         w0_n[tgt_bit]  = (cls == want);
            end
        end else if (sel == SEL_OP) begin
            if (data <= DATA_W'(OP_MAX) &&
                !(data > DATA_W'(OP_OLD_MAX) && w0[CLS_W-1:0] < CLS_OLD_LIMIT)) begin
                ok    = 1'b1;
                reval = 1'b1;
                w0_n[B_OP_LO+2:B_OP_LO] = data[2:0];
            end
        end else if (sel == SEL_SURF2D || sel == SEL_SURF2D_SW) begin
            if (cls == CLS_NULL) begin
                ok = 1'b1; reval = 1'b1;
                w0_n[B_SWZ] = 1'b0; aux_n[B_DST] = 1'b0;
            end else if (cls == CLS_SURF2D) begin
                ok = 1'b1; reval = 1'b1;
                w0_n[B_SWZ] = 1'b0; aux_n[B_DST] = 1'b1;
            end else if (sel == SEL_SURF2D_SW && cls == CLS_SWZ) begin
                ok = 1'b1; reval = 1'b1;
                w0_n[B_SWZ] = 1'b1; aux_n[B_DST] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/bbt_validity.sv
module bbt_validity
    import bbt_pkg::*;
(
    input  logic [CLS_W-1:0] cls,
    input  logic [2:0]       op,
    input  logic [5:0]       flags,   // aux bits 30:25
    output logic             valid
);
    logic dst, src, patt, rop, bl1, bl4;
    logic need_ok;

    assign {bl4, bl1, rop, patt, src, dst} = flags;

    always_comb begin
        unique case (op)
            3'd1:       need_ok = patt | rop;
            3'd2:       need_ok = bl1;
            3'd4, 3'd5: need_ok = bl4;
            default:    need_ok = 1'b1;
        endcase
    end

    assign valid = dst && need_ok &&
                   !((cls == CLS_TWO_SRC_A || cls == CLS_TWO_SRC_B) && !src);
endmodule

// File: rtl/blit_bind_tracker.sv
module blit_bind_tracker
    import bbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CLS_W-1:0]  init_class,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CLS_W-1:0]  wr_class,
    output logic [WORD_W-1:0] obj_word0,
    output logic [WORD_W-1:0] obj_aux,
    output logic              err_pulse,
    output logic              patch_valid
);
    bbt_state_e        state_q, state_d;
    logic [WORD_W-1:0] w0_q, aux_q, w0_n, aux_n;
    logic              ok, reval, valid_calc, valid_q, err_q;
    logic              start;

    bbt_decode u_dec (
        .sel   (wr_sel),
        .cls   (wr_class),
        .data  (wr_data),
        .w0    (w0_q),
        .aux   (aux_q),
        .ok    (ok),
        .reval (reval),
        .w0_n  (w0_n),
        .aux_n (aux_n)
    );

    bbt_validity u_val (
        .cls   (w0_q[CLS_W-1:0]),
        .op    (w0_q[B_OP_LO+2:B_OP_LO]),
        .flags (aux_q[B_BL4:B_DST]),
        .valid (valid_calc)
    );

    assign start = wr_en && ok && reval;

    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = start ? ST_REVAL : ST_IDLE;
            ST_REVAL: state_d = start ? ST_REVAL : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w0_q    <= {{(WORD_W-CLS_W){1'b0}}, init_class};
            aux_q   <= '0;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            err_q <= wr_en && !ok;
            if (wr_en && ok) begin
                w0_q  <= w0_n;
                aux_q <= aux_n;
            end
            if (state_q == ST_REVAL) valid_q <= valid_calc;
        end
    end

    assign obj_word0   = {w0_q[WORD_W-1:B_VALID+1], valid_q, w0_q[B_VALID-1:0]};
    assign obj_aux     = aux_q;
    assign err_pulse   = err_q;
    assign patch_valid = valid_q;
endmodule

// File: rtl/bbt_chk.sv
module bbt_chk
    import bbt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [SEL_W-1:0]  wr_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic [CLS_W-1:0]  wr_class,
    input logic [WORD_W-1:0] obj_word0,
    input logic [WORD_W-1:0] obj_aux,
    input logic              err_pulse,
    input logic              patch_valid
);
    // R6
    reject_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> ($stable(obj_aux) && $stable(obj_word0[23:0])));

    // R2
    op_range_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_OP && wr_data > DATA_W'(OP_MAX)) |=> err_pulse);

    // R2
    op_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_OP && wr_data <= DATA_W'(OP_OLD_MAX))
        |=> (obj_word0[17:15] == $past(wr_data[2:0]) && !err_pulse));

    // R6
    rop_unknown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_ROP && wr_class != CLS_ROP && wr_class != CLS_NULL)
        |=> err_pulse);

    // R5
    clip_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CLIP && wr_class == CLS_CLIP) |=> obj_word0[13]);

    // R7
    valid_needs_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        patch_valid |-> $past(obj_aux[25]));

    // R8
    valid_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        obj_word0[24] == patch_valid);
endmodule

bind blit_bind_tracker bbt_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .wr_class    (wr_class),
    .obj_word0   (obj_word0),
    .obj_aux     (obj_aux),
    .err_pulse   (err_pulse),
    .patch_valid (patch_valid)
);

// File: tb/blit_bind_tracker_tb.sv
module blit_bind_tracker_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  init_class = 8'h5f;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  wr_class = '0;
    logic [31:0] obj_word0, obj_aux;
    logic        err_pulse, patch_valid;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    blit_bind_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .init_class(init_class),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .wr_class(wr_class),
        .obj_word0(obj_word0), .obj_aux(obj_aux),
        .err_pulse(err_pulse), .patch_valid(patch_valid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [7:0] cls);
        @(negedge clk);
        rst_n = 1'b0;
        init_class = cls;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drives one write; returns at the negedge after the capturing edge.
    task automatic do_write(input logic [3:0] sel, input logic [7:0] cls, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_class = cls; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    function automatic logic exp_valid(input logic [7:0] cls, input int op, input logic [5:0] f);
        logic v;
        v = f[0];
        if ((cls == 8'h1f || cls == 8'h48) && !f[1]) v = 1'b0;
        case (op)
            1: if (!(f[2] | f[3])) v = 1'b0;
            2: if (!f[4]) v = 1'b0;
            4, 5: if (!f[5]) v = 1'b0;
            default: ;
        endcase
        return v;
    endfunction

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] cls_list [5];
        logic [7:0] set_cls [6];
        logic [3:0] set_sel [6];
        cls_list = '{8'h1f, 8'h48, 8'h5f, 8'h37, 8'h4a};
        set_sel  = '{4'd8, 4'd9, 4'd2, 4'd3, 4'd4, 4'd5};
        set_cls  = '{8'h58, 8'h59, 8'h44, 8'h43, 8'h12, 8'h72};

        // R1: reset state, checked during and after reset
        init_class = 8'h5f;
        #(CLK_PERIOD * 2);
        check("R1 word0 in reset", obj_word0, 32'h0000005f);
        check("R1 aux in reset", obj_aux, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        idle();
        check("R1 word0 after reset", obj_word0, 32'h0000005f);
        check("R1 aux/err/valid", {obj_aux[30:0], err_pulse, patch_valid}, 32'h0);

        // R3 / R8: bind destination then check timing of valid
        do_write(4'd8, 8'h58, 0);
        check("R3 dst bit set", obj_aux, 32'h02000000);
        check("R8 valid not yet updated", {31'b0, patch_valid}, 32'h0);
        idle();
        check("R8 valid after one edge", {31'b0, patch_valid}, 32'h1);
        check("R8 valid mirrored in word0", obj_word0, 32'h0100005f);

        // R6: unknown class on rop bind
        do_write(4'd3, 8'h44, 0);
        check("R6 err pulse", {31'b0, err_pulse}, 32'h1);
        check("R6 aux unchanged", obj_aux, 32'h02000000);
        idle();
        check("R6 err single cycle", {31'b0, err_pulse}, 32'h0);
        // R6: unused selector
        do_write(4'd14, 8'h30, 0);
        check("R6 bad selector err", {31'b0, err_pulse}, 32'h1);
        check("R6 bad selector no change", obj_word0, 32'h0100005f);

        // R2: op >5 rejected
        do_write(4'd0, 8'h00, 32'd6);
        check("R2 op 6 rejected", {31'b0, err_pulse}, 32'h1);
        check("R2 op unchanged", {29'b0, obj_word0[17:15]}, 32'h0);
        do_write(4'd0, 8'h00, 32'h100);
        check("R2 large op rejected", {31'b0, err_pulse}, 32'h1);

        // R3: old pattern class, null clears
        do_write(4'd1, 8'h18, 0);
        check("R3 old pattern set", {31'b0, obj_aux[27]}, 32'h1);
        do_write(4'd1, 8'h44, 0);
        check("R3 old pattern rejects new class", {31'b0, err_pulse}, 32'h1);
        do_write(4'd1, 8'h30, 0);
        check("R3 null clears pattern", {31'b0, obj_aux[27]}, 32'h0);
        do_write(4'd10, 8'h5a, 0);
        do_write(4'd11, 8'h5b, 0);
        check("R3 colour/depth bits", obj_aux, 32'h06000000);
        do_write(4'd10, 8'h30, 0);
        check("R3 colour null clears bit 25", obj_aux, 32'h04000000);

        // R4: 2D surface binds
        do_write(4'd7, 8'h52, 0);
        check("R4 swizzle sets 14 and 25", {obj_word0[14], obj_aux[25]}, 32'h3);
        do_write(4'd6, 8'h52, 0);
        check("R4 plain surf rejects 0x52", {31'b0, err_pulse}, 32'h1);
        check("R4 swizzle kept", {31'b0, obj_word0[14]}, 32'h1);
        do_write(4'd6, 8'h42, 0);
        check("R4 0x42 clears 14 sets 25", {obj_word0[14], obj_aux[25]}, 32'h1);
        do_write(4'd7, 8'h52, 0);
        do_write(4'd7, 8'h30, 0);
        check("R4 null clears 14 and 25", {obj_word0[14], obj_aux[25]}, 32'h0);
        idle();
        check("R7 invalid without dst", {31'b0, patch_valid}, 32'h0);

        // R5 / R8: clip and colour key do not start a recompute
        do_write(4'd8, 8'h58, 0);
        idle();
        check("R8 valid back", {31'b0, patch_valid}, 32'h1);
        do_write(4'd8, 8'h30, 0);
        do_write(4'd12, 8'h19, 0);
        do_write(4'd13, 8'h57, 0);
        check("R5 clip and key bits", {30'b0, obj_word0[13:12]}, 32'h3);
        idle();
        check("R8 dst cleared then valid drops", {31'b0, patch_valid}, 32'h0);
        do_write(4'd12, 8'h30, 0);
        check("R5 clip null clears", {30'b0, obj_word0[13:12]}, 32'h1);
        do_write(4'd13, 8'h17, 0);
        check("R5 key rejects 0x17", {31'b0, err_pulse}, 32'h1);

        // R7 / R2: exhaustive sweep of class x operation x bound flags
        for (int ci = 0; ci < 5; ci++) begin
            for (int op = 0; op <= 5; op++) begin
                for (int m = 0; m < 64; m++) begin
                    logic rej;
                    int   eop;
                    do_reset(cls_list[ci]);
                    for (int b = 0; b < 6; b++)
                        do_write(set_sel[b], m[b] ? set_cls[b] : 8'h30, 0);
                    do_write(4'd0, 8'h00, 32'(op));
                    rej = (op > 2) && (cls_list[ci] < 8'h40);
                    eop = rej ? 0 : op;
                    check("R2 op accept/reject", {31'b0, err_pulse}, {31'b0, rej});
                    idle();
                    check("R2 op field", {29'b0, obj_word0[17:15]}, 32'(eop));
                    check("R7 valid sweep", {31'b0, patch_valid},
                          {31'b0, exp_valid(cls_list[ci], eop, m[5:0])});
                end
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule